// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block turns a bank of synchronized GPIO inputs into latched interrupt status bits and one bank interrupt line. The bank is split into ports of eight pins. Each port takes one configuration word three byte lanes wide, which picks a trigger type for every pin: rising edge, falling edge, both edges, active-high level or active-low level.

A register file outside the block decodes software accesses. It supplies the configuration words, a per-pin enable mask and single-cycle write-one-to-clear pulses. The block holds the status bits. A bit is pending when its status bit and its enable bit are both set. The registered bank interrupt goes high when any pin in any port is pending.

Edges are latched in hardware. Software can clear a bit while it is still handling the earlier event, and a new edge is never lost.

Top module: `gpint_bank`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears every status bit, the bank interrupt and every pin's input history. The history resets to 0, so a pin that is high in the first cycle after reset counts as a rising edge.
- R2: For pin b of port p, the trigger code is three bits of that port's word `lvl_cfg_i[p*24 +: 24]`: bit b is polarity, bit 8+b is the edge-mode flag and bit 16+b is the both-edges flag.
- R3: With code 011 (both/edge/polarity), a 0-to-1 change between two sampled cycles sets the status bit, visible one clock after the high sample. A 1-to-0 change does not set it. Once set, the bit stays set until it is cleared.
- R4: Code 010 sets status on a 1-to-0 change only. Codes 110 and 111 set status on any change; polarity is ignored when the both-edges flag is set in edge mode.
- R5: Code 001 sets status in every cycle the input is 1. Code 000 sets status in every cycle the input is 0. A clear has no lasting effect while the active level persists.
- R6: A 1 on `clr_i[n]` for one cycle clears status bit n at the next clock, unless bit n is set in that same cycle. A 0 on `clr_i[n]` leaves bit n unchanged.
- R7: If a clear and a new trigger event hit the same pin in the same cycle, the status bit stays set.
- R8: Status bits latch whatever the enable mask holds. A disabled set bit does not raise the bank interrupt.
- R9: `bank_irq_o` is registered. It equals, one clock later, the OR across all pins of all ports of status AND enable.
- R10: When the edge flag is 0, the both-edges flag is ignored. Code 101 acts as active-high level and code 100 acts as active-low level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | PORTS*PINS | Synchronized pin levels, pin n = port n/PINS, bit n%PINS |
| lvl_cfg_i | input | PORTS*3*PINS | Per-port trigger words, port p at [p*3*PINS +: 3*PINS] |
| en_i | input | PORTS*PINS | Interrupt enable mask per pin |
| clr_i | input | PORTS*PINS | Write-one-to-clear pulses per pin |
| status_o | output | PORTS*PINS | Latched status bits |
| bank_irq_o | output | 1 | Registered bank interrupt |

## Verification
The bench builds the block with its defaults: four ports of eight pins, so 32 pins and a 96-bit configuration bus. With that size every byte lane of every port word is in play. It also puts a pending pin in the last port alone, which shows that the interrupt OR reaches across port boundaries. All eight trigger codes are placed on pins in different ports. The clear-versus-event collision is exercised under both edge and level triggers, before a random phase that also rewrites the configuration while the block runs.

// File: rtl/gpint_pkg.sv
package gpint_pkg;

  localparam int unsigned CODE_W = 3;

  typedef enum logic [2:0] {
    TRIG_LVL_LO = 3'd0,
    TRIG_LVL_HI = 3'd1,
    TRIG_RISE   = 3'd2,
    TRIG_FALL   = 3'd3,
    TRIG_BOTH   = 3'd4
  } trig_e;

  // code = {both, edge, polarity}
  function automatic trig_e decode_trig(input logic [CODE_W-1:0] code);
    trig_e m;
    if (!code[1])      m = code[0] ? TRIG_LVL_HI : TRIG_LVL_LO;
    else if (code[2])  m = TRIG_BOTH;
    else               m = code[0] ? TRIG_RISE : TRIG_FALL;
    return m;
  endfunction

endpackage

// File: rtl/gpint_pin_cell.sv
module gpint_pin_cell
  import gpint_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              clr_i,
  output logic              status_o
);

  trig_e mode;
  logic  prev_q, prev_d;
  logic  stat_q, stat_d, stat_en;
  logic  hit;

  assign mode = decode_trig(code_i);

  always_comb begin
    case (mode)
      TRIG_RISE:   hit = pin_i & ~prev_q;
      TRIG_FALL:   hit = ~pin_i & prev_q;
      TRIG_BOTH:   hit = pin_i ^ prev_q;
      TRIG_LVL_HI: hit = pin_i;
      default:     hit = ~pin_i;
    endcase
  end

  always_comb begin
    prev_d  = pin_i;
    stat_en = hit | clr_i;
    stat_d  = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      if (stat_en) stat_q <= stat_d;
    end
  end

  assign status_o = stat_q;

  AST_HOLD_UNCLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !clr_i) |=> stat_q); // R6
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hit) |=> !stat_q); // R6
  AST_EVENT_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && hit) |=> stat_q); // R7
  AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i == 3'b011 && pin_i && !prev_q) |=> stat_q); // R3
  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i[1:0] == 2'b01 && pin_i) |=> stat_q); // R5
  AST_QUIET_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_q && !hit) |=> !stat_q); // R3

endmodule

// File: rtl/gpint_port.sv
module gpint_port
  import gpint_pkg::*;
#(
  parameter int unsigned PINS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PINS-1:0]        pin_i,
  input  logic [CODE_W*PINS-1:0] cfg_i,
  input  logic [PINS-1:0]        en_i,
  input  logic [PINS-1:0]        clr_i,
  output logic [PINS-1:0]        status_o,
  output logic                   pend_o
);

  localparam int unsigned EDGE_LANE = PINS;
  localparam int unsigned BOTH_LANE = 2 * PINS;

  for (genvar b = 0; b < PINS; b++) begin : g_pin
    logic [CODE_W-1:0] code;
    assign code = {cfg_i[BOTH_LANE+b], cfg_i[EDGE_LANE+b], cfg_i[b]};

    gpint_pin_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_i    (pin_i[b]),
      .code_i   (code),
      .clr_i    (clr_i[b]),
      .status_o (status_o[b])
    );
  end

  assign pend_o = |(status_o & en_i);

endmodule

// File: rtl/gpint_irq_merge.sv
module gpint_irq_merge #(
  parameter int unsigned PORTS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PORTS-1:0] pend_i,
  output logic             irq_o
);

  logic irq_q, irq_d;

  always_comb irq_d = |pend_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_i) |=> irq_o); // R9
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i == '0) |=> !irq_o); // R9

endmodule

// File: rtl/gpint_bank.sv
module gpint_bank
  import gpint_pkg::*;
#(
  parameter int unsigned PORTS = 4,
  parameter int unsigned PINS  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [PORTS*PINS-1:0]        pin_i,
  input  logic [PORTS*CODE_W*PINS-1:0] lvl_cfg_i,
  input  logic [PORTS*PINS-1:0]        en_i,
  input  logic [PORTS*PINS-1:0]        clr_i,
  output logic [PORTS*PINS-1:0]        status_o,
  output logic                         bank_irq_o
);

  localparam int unsigned WORD_W = CODE_W * PINS;

  logic [PORTS-1:0] pend;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    gpint_port #(.PINS(PINS)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_i    (pin_i[p*PINS +: PINS]),
      .cfg_i    (lvl_cfg_i[p*WORD_W +: WORD_W]),
      .en_i     (en_i[p*PINS +: PINS]),
      .clr_i    (clr_i[p*PINS +: PINS]),
      .status_o (status_o[p*PINS +: PINS]),
      .pend_o   (pend[p])
    );
  end

  gpint_irq_merge #(.PORTS(PORTS)) u_merge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (pend),
    .irq_o  (bank_irq_o)
  );

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i == '0) |=> !bank_irq_o); // R8

endmodule

// File: tb/gpint_bank_tb_top.sv
module gpint_bank_tb_top;

  localparam int PORTS = 4;
  localparam int PINS  = 8;
  localparam int NPIN  = PORTS * PINS;
  localparam int WW    = 3 * PINS;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NPIN-1:0] pin, en, clr;
  logic [3*NPIN-1:0] cfg;
  logic [NPIN-1:0] status;
  logic            irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  gpint_bank #(.PORTS(PORTS), .PINS(PINS)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .lvl_cfg_i(cfg),
    .en_i(en), .clr_i(clr), .status_o(status), .bank_irq_o(irq)
  );

  // behavioural reference
  bit m_stat [NPIN];
  bit m_prev [NPIN];
  bit m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPIN; i++) begin m_stat[i] = 0; m_prev[i] = 0; end
      m_irq = 0;
    end else begin
      bit any;
      any = 0;
      for (int i = 0; i < NPIN; i++) if (m_stat[i] && en[i]) any = 1;
      for (int i = 0; i < NPIN; i++) begin
        int base, b, code;
        bit ev;
        base = (i / PINS) * WW;
        b    = i % PINS;
        code = 4 * cfg[base+16+b] + 2 * cfg[base+8+b] + cfg[base+b];
        case (code)
          3:       ev = pin[i] && !m_prev[i];
          2:       ev = !pin[i] && m_prev[i];
          6, 7:    ev = pin[i] != m_prev[i];
          1, 5:    ev = pin[i];
          default: ev = !pin[i];
        endcase
        if (clr[i]) m_stat[i] = 0;
        if (ev)     m_stat[i] = 1;
        m_prev[i] = pin[i];
      end
      m_irq = any;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [NPIN-1:0] exp_s;
      for (int i = 0; i < NPIN; i++) exp_s[i] = m_stat[i];
      n_chk++;
      if (status !== exp_s) begin
        n_err++;
        $display("FAIL R3 status per-cycle: actual %h expected %h", status, exp_s);
      end
      n_chk++;
      if (irq !== m_irq) begin
        n_err++;
        $display("FAIL R9 irq per-cycle: actual %0b expected %0b", irq, m_irq);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_code(input int n, input logic [2:0] code);
    int base, b;
    base = (n / PINS) * WW;
    b    = n % PINS;
    cfg[base+b]    = code[0];
    cfg[base+8+b]  = code[1];
    cfg[base+16+b] = code[2];
  endtask

  initial begin
    rst_n = 1'b0; pin = '0; en = '0; clr = '0; cfg = '0;
    for (int i = 0; i < NPIN; i++) set_code(i, 3'b011);
    set_code(1, 3'b010);
    set_code(2, 3'b110);
    set_code(3, 3'b111);
    set_code(8, 3'b001);
    set_code(16, 3'b000);
    set_code(24, 3'b101);
    set_code(25, 3'b100);
    pin[4] = 1'b1;
    repeat (3) tick();
    chk("R1 status in reset", status, 32'h0);
    chk("R1 irq in reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    tick();
    chk("R1 high pin after reset is a rising edge", {31'b0, status[4]}, 32'h1);
    chk("R5 level-low pin set at once", {31'b0, status[16]}, 32'h1);
    chk("R10 code 100 acts as level low", {31'b0, status[25]}, 32'h1);
    chk("R2 code 011 quiet pin", {31'b0, status[0]}, 32'h0);

    pin[0] = 1'b1; tick();
    chk("R3 rising sets status", {31'b0, status[0]}, 32'h1);
    chk("R8 latched but disabled, no irq", {31'b0, irq}, 32'h0);
    pin[0] = 1'b0; tick();
    chk("R3 falling ignored, bit held", {31'b0, status[0]}, 32'h1);
    en[0] = 1'b1; tick();
    chk("R9 irq one clock after enable", {31'b0, irq}, 32'h1);
    clr[0] = 1'b1; tick();
    chk("R6 one clears", {31'b0, status[0]}, 32'h0);
    chk("R9 irq lags the clear", {31'b0, irq}, 32'h1);
    clr = '0; tick();
    chk("R9 irq drops", {31'b0, irq}, 32'h0);
    en = '0;
    clr = 32'hFFFF_FFEF; tick();
    chk("R6 zero leaves bit", {31'b0, status[4]}, 32'h1);
    clr = '0;

    pin[0] = 1'b1; tick();
    pin[0] = 1'b0; tick();
    pin[0] = 1'b1; clr[0] = 1'b1; tick();
    chk("R7 clear and edge together keep bit", {31'b0, status[0]}, 32'h1);
    tick();
    chk("R6 clear with pin steady high", {31'b0, status[0]}, 32'h0);
    clr = '0;

    pin[1] = 1'b1; tick();
    chk("R4 falling mode ignores rise", {31'b0, status[1]}, 32'h0);
    pin[1] = 1'b0; tick();
    chk("R4 falling mode sets", {31'b0, status[1]}, 32'h1);
    pin[3:2] = 2'b11; tick();
    chk("R4 both-edge up", {30'b0, status[3:2]}, 32'h3);
    clr[3:2] = 2'b11; tick();
    chk("R4 both-edge cleared", {30'b0, status[3:2]}, 32'h0);
    clr = '0; pin[3:2] = 2'b00; tick();
    chk("R4 both-edge down", {30'b0, status[3:2]}, 32'h3);

    pin[8] = 1'b1; tick();
    chk("R5 level high sets", {31'b0, status[8]}, 32'h1);
    clr[8] = 1'b1; tick();
    chk("R5 clear ineffective while high", {31'b0, status[8]}, 32'h1);
    pin[8] = 1'b0; tick();
    chk("R5 clear works once level gone", {31'b0, status[8]}, 32'h0);
    clr = '0;
    pin[16] = 1'b1; clr[16] = 1'b1; tick();
    chk("R5 level low cleared when input high", {31'b0, status[16]}, 32'h0);
    clr = '0; pin[16] = 1'b0; tick();
    chk("R5 level low sets again", {31'b0, status[16]}, 32'h1);

    pin[24] = 1'b1; tick();
    chk("R10 code 101 acts as level high", {31'b0, status[24]}, 32'h1);
    clr[24] = 1'b1; tick();
    chk("R10 level hold against clear", {31'b0, status[24]}, 32'h1);
    pin[24] = 1'b0; tick();
    chk("R10 cleared after level drops", {31'b0, status[24]}, 32'h0);
    clr = '0;

    en = 32'h0100_0000; pin[24] = 1'b1; tick();
    tick();
    chk("R9 last port alone raises irq", {31'b0, irq}, 32'h1);
    en = '0; tick();
    chk("R9 irq falls after enable drop", {31'b0, irq}, 32'h0);

    for (int k = 0; k < 400; k++) begin
      pin = $urandom();
      en  = $urandom();
      clr = $urandom() & $urandom();
      if (k % 50 == 0)
        for (int i = 0; i < NPIN; i++) set_code(i, 3'($urandom()));
      tick();
    end
    clr = '0;
    tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule